// File: doc/BRIEF.md
# Atomic Read-Then-Write Bus Sequencer

This block carries out one indivisible read-modify-write on a simple single-beat external bus. A requester pulses a start input with an address and a store value. The block reads that address, keeps the returned word, waits one idle cycle so that the data-bus drivers can turn around, and then writes the store value to the same address. A lock output stays asserted from the read's address strobe to the last cycle of the write. No other bus access can start in between, so an external arbiter or memory can treat the pair as one atomic unit.

Each bus access opens with an address strobe that is low for one cycle. It closes in the first later cycle where ready is low. A memory exception signalled together with ready ends the access at once. If the read faults, the write is dropped, the lock is released and a read-fault status is returned. If the write faults, a write-fault status is returned. Each operation ends with a one-cycle completion pulse that carries a status code and the last word read successfully.

Top module: `rmw_bus_seq`

## Requirements
- R1: During reset and in the first cycle after it: `bus_as_n`=1, `bus_lock_n`=1, `bus_doe`=0, `busy`=0, `done`=0. A reset in the middle of an operation returns the outputs to this state.
- R2: A `req_start` seen in an idle cycle makes the next cycle the read strobe cycle. In that cycle `bus_as_n`=0, `bus_rd_wr`=1, `bus_lock_n`=0 and `bus_addr`=`req_addr`. The strobe lasts exactly one cycle.
- R3: A read ends on the first cycle after its strobe with `bus_ready_n`=0 and `bus_mexc_n`=1, and `bus_din` is captured then. Next comes exactly one turnaround cycle (`bus_as_n`=1, `bus_doe`=0, lock held). The cycle after it is the write strobe cycle: `bus_as_n`=0, `bus_rd_wr`=0, the same `bus_addr`, and `bus_dout`=the store value.
- R4: `bus_lock_n` stays 0 in every cycle from the read strobe up to and including the cycle where the final ready is sampled. It is 1 in the cycle after that.
- R5: `bus_doe`=1 only in the write strobe cycle and the write wait cycles, and `bus_rd_wr`=0 exactly in those cycles.
- R6: In the cycle after the write's ready, `done`=1 for one cycle and `busy`=0. `resp` is 0 (ok), or 2 (write fault) if `bus_mexc_n` was 0 with ready. `rdata` equals the word captured by the read.
- R7: A read that ends with `bus_mexc_n`=0 issues no write strobe. In the next cycle `bus_lock_n`=1, `done`=1 and `resp`=1 (read fault), and `rdata` keeps its earlier value: the bus data is ignored.
- R8: `req_start` while an operation is running has no effect on its address, its store data or the cycles after it. `bus_ready_n` is ignored in idle, strobe and turnaround cycles.
- R9: `busy`=1 in every cycle from the read strobe to the final ready cycle, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Starts an atomic operation when idle |
| req_addr | input | ADDR_W | Target address |
| req_wdata | input | DATA_W | Value to store |
| busy | output | 1 | Operation in progress (bus held) |
| done | output | 1 | One-cycle completion pulse |
| resp | output | 2 | Completion status: 0 ok, 1 read fault, 2 write fault |
| rdata | output | DATA_W | Word captured by the last good read |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_rd_wr | output | 1 | 1 read, 0 write |
| bus_lock_n | output | 1 | Bus lock, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Write data |
| bus_doe | output | 1 | Write data driver enable |
| bus_din | input | DATA_W | Read data |
| bus_ready_n | input | 1 | Access complete, active low |
| bus_mexc_n | input | 1 | Memory exception with ready, active low |

## Verification
A phase register in the wrong state shows at the bus within one cycle. It appears as a strobe in an unexpected cycle, an early write strobe with no turnaround, a driver enable during the read, or the lock dropping early. If a read fault is mishandled, a write strobe shows up two cycles after the faulting ready. A wrong capture register only shows at `rdata` and `resp` on the completion pulse, so the bench compares those against the bus data it supplied, and it feeds fault data that must not reach `rdata`.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_RD_AS   = 3'd1,
      PH_RD_WAIT = 3'd2,
      PH_TURN    = 3'd3,
      PH_WR_AS   = 3'd4,
      PH_WR_WAIT = 3'd5
   } phase_e;

   typedef enum logic [1:0] {
      RESP_OK     = 2'd0,
      RESP_RD_EXC = 2'd1,
      RESP_WR_EXC = 2'd2
   } resp_e;

   typedef struct packed {
      logic strobe;
      logic hold;
      logic write;
      logic drive;
   } bus_ctl_t;

endpackage

// File: rtl/rmw_seq_fsm.sv
module rmw_seq_fsm
   import rmw_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   rdy,
   input  logic   fault,
   output phase_e phase,
   output logic   accept,
   output logic   rd_take,
   output logic   fin,
   output resp_e  fin_resp
);

   phase_e phase_q, phase_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   always_comb begin
      phase_d = phase_q;
      case (phase_q)
         PH_IDLE:    if (start) phase_d = PH_RD_AS;
         PH_RD_AS:   phase_d = PH_RD_WAIT;
         PH_RD_WAIT: if (rdy) phase_d = fault ? PH_IDLE : PH_TURN;
         PH_TURN:    phase_d = PH_WR_AS;
         PH_WR_AS:   phase_d = PH_WR_WAIT;
         PH_WR_WAIT: if (rdy) phase_d = PH_IDLE;
         default:    phase_d = PH_IDLE;
      endcase
   end

   always_comb begin
      accept   = (phase_q == PH_IDLE) && start;
      rd_take  = (phase_q == PH_RD_WAIT) && rdy && !fault;
      fin      = rdy && ((phase_q == PH_WR_WAIT) ||
                         ((phase_q == PH_RD_WAIT) && fault));
      fin_resp = RESP_OK;
      if (phase_q == PH_RD_WAIT)  fin_resp = RESP_RD_EXC;
      else if (fault)             fin_resp = RESP_WR_EXC;
   end

   assign phase = phase_q;

endmodule

// File: rtl/rmw_req_regs.sv
module rmw_req_regs
   import rmw_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              rd_take,
   input  logic              fin,
   input  resp_e             fin_resp,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   input  logic [DATA_W-1:0] in_rdata,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              done_q,
   output resp_e             resp_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= in_addr;
         wdata_q <= in_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (rd_take) rdata_q <= in_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         resp_q <= RESP_OK;
      end else begin
         done_q <= fin;
         if (fin) resp_q <= fin_resp;
      end
   end

endmodule

// File: rtl/rmw_bus_drive.sv
module rmw_bus_drive
   import rmw_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit DOUT_PARK = 1'b0
) (
   input  phase_e            phase,
   input  logic [DATA_W-1:0] wdata,
   output bus_ctl_t          ctl,
   output logic [DATA_W-1:0] dout
);

   always_comb begin
      ctl.strobe = (phase == PH_RD_AS) || (phase == PH_WR_AS);
      ctl.hold   = (phase != PH_IDLE);
      ctl.write  = (phase == PH_WR_AS) || (phase == PH_WR_WAIT);
      ctl.drive  = ctl.write;
   end

   generate
      if (DOUT_PARK) begin : g_park
         assign dout = wdata;
      end else begin : g_zero
         assign dout = ctl.drive ? wdata : '0;
      end
   endgenerate

endmodule

// File: rtl/rmw_bus_seq.sv
module rmw_bus_seq
   import rmw_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter bit DOUT_PARK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [1:0]        resp,
   output logic [DATA_W-1:0] rdata,
   output logic              bus_as_n,
   output logic              bus_rd_wr,
   output logic              bus_lock_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              bus_ready_n,
   input  logic              bus_mexc_n
);

   generate
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr
         $error("rmw_bus_seq: ADDR_W out of range");
      end
      if (DATA_W < 8 || DATA_W > 128) begin : g_bad_data
         $error("rmw_bus_seq: DATA_W out of range");
      end
   endgenerate

   phase_e   phase;
   logic     accept, rd_take, fin;
   resp_e    fin_resp, resp_q;
   bus_ctl_t ctl;
   logic [DATA_W-1:0] wdata_q;

   rmw_seq_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (req_start),
      .rdy      (!bus_ready_n),
      .fault    (!bus_mexc_n),
      .phase    (phase),
      .accept   (accept),
      .rd_take  (rd_take),
      .fin      (fin),
      .fin_resp (fin_resp)
   );

   rmw_req_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .rd_take  (rd_take),
      .fin      (fin),
      .fin_resp (fin_resp),
      .in_addr  (req_addr),
      .in_wdata (req_wdata),
      .in_rdata (bus_din),
      .addr_q   (bus_addr),
      .wdata_q  (wdata_q),
      .rdata_q  (rdata),
      .done_q   (done),
      .resp_q   (resp_q)
   );

   rmw_bus_drive #(.DATA_W(DATA_W), .DOUT_PARK(DOUT_PARK)) u_drv (
      .phase (phase),
      .wdata (wdata_q),
      .ctl   (ctl),
      .dout  (bus_dout)
   );

   assign resp       = resp_q;
   assign busy       = ctl.hold;
   assign bus_as_n   = !ctl.strobe;
   assign bus_rd_wr  = !ctl.write;
   assign bus_lock_n = !ctl.hold;
   assign bus_doe    = ctl.drive;

endmodule

// File: rtl/rmw_bus_seq_chk.sv
module rmw_bus_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic [1:0] resp,
   input logic       bus_as_n,
   input logic       bus_rd_wr,
   input logic       bus_lock_n,
   input logic       bus_doe,
   input logic       bus_ready_n,
   input logic       bus_mexc_n
);

   logic rd_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rd_open <= 1'b0;
      else if (!bus_as_n && bus_rd_wr)  rd_open <= 1'b1;
      else if (!bus_ready_n)            rd_open <= 1'b0;
   end

   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_as_n |=> bus_as_n);

   // R4
   lock_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_as_n |-> !bus_lock_n);

   // R5
   doe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_doe |-> (!bus_rd_wr && !bus_lock_n));

   // R3
   turn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_open && !bus_ready_n && bus_mexc_n) |=> (bus_as_n && !bus_doe && !bus_lock_n));

   // R3
   write_after_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_open && !bus_ready_n && bus_mexc_n) |-> ##2 (!bus_as_n && !bus_rd_wr));

   // R7
   rd_fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_open && !bus_ready_n && !bus_mexc_n) |=>
         (bus_as_n && bus_lock_n && done && resp == 2'd1));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && bus_lock_n));

   // R9
   busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !bus_lock_n);

endmodule

bind rmw_bus_seq rmw_bus_seq_chk u_chk (.*);

// File: tb/tb_rmw_bus_seq.sv
`timescale 1ns/1ps
module tb_rmw_bus_seq;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_start;
   logic [31:0] req_addr, req_wdata;
   logic        busy, done;
   logic [1:0]  resp;
   logic [31:0] rdata;
   logic        bus_as_n, bus_rd_wr, bus_lock_n, bus_doe;
   logic [31:0] bus_addr, bus_dout, bus_din;
   logic        bus_ready_n, bus_mexc_n;

   int total = 0;
   int fails = 0;
   logic [31:0] exp_rdata = '0;

   always #10 clk = ~clk;

   rmw_bus_seq dut (.*);

   typedef struct packed {
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [31:0] rbus;
      logic [1:0]  rwait;
      logic [1:0]  wwait;
      logic        rexc;
      logic        wexc;
      logic        poke;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VEC [NV] = '{
      '{32'h0000_1000, 32'hA5A5_0001, 32'h1234_5678, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0},
      '{32'h8000_0FFC, 32'hFFFF_FFFF, 32'h0000_0000, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1},
      '{32'h0000_0040, 32'h0000_00EE, 32'hDEAD_BEEF, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0},
      '{32'h7FFF_FFF0, 32'h1357_9BDF, 32'hCAFE_F00D, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0},
      '{32'h0000_0001, 32'h0000_0000, 32'h0F0F_0F0F, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1}
   };

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle_chk(input string req);
      chk(req, "as_n", bus_as_n, 1);
      chk(req, "lock_n", bus_lock_n, 1);
      chk(req, "doe", bus_doe, 0);
      chk(req, "busy", busy, 0);
   endtask

   task automatic run_op(input vec_t v);
      @(negedge clk);
      req_start = 1'b1; req_addr = v.addr; req_wdata = v.wdata;
      @(negedge clk);                                    // read strobe
      chk("R2", "rd strobe as_n", bus_as_n, 0);
      chk("R2", "rd strobe rd_wr", bus_rd_wr, 1);
      chk("R2", "rd strobe addr", bus_addr, v.addr);
      chk("R4", "lock at rd strobe", bus_lock_n, 0);
      chk("R5", "no doe in read", bus_doe, 0);
      chk("R9", "busy at rd strobe", busy, 1);
      req_start   = v.poke;
      req_addr    = ~v.addr; req_wdata = ~v.wdata;
      bus_ready_n = !v.poke;                             // R8 ignored at strobe
      @(negedge clk);                                    // first read wait
      req_start = 1'b0; bus_ready_n = 1'b1;
      chk("R2", "strobe one cycle", bus_as_n, 1);
      for (int i = 0; i < int'(v.rwait); i++) begin
         @(negedge clk);
         chk("R8", "still in read wait", bus_as_n, 1);
         chk("R4", "lock in read wait", bus_lock_n, 0);
      end
      bus_ready_n = 1'b0; bus_mexc_n = !v.rexc; bus_din = v.rbus;
      @(negedge clk);
      bus_ready_n = 1'b1; bus_mexc_n = 1'b1; bus_din = 32'h5555_AAAA;
      if (v.rexc) begin
         chk("R7", "lock released", bus_lock_n, 1);
         chk("R7", "done", done, 1);
         chk("R7", "resp", resp, 1);
         chk("R7", "rdata kept", rdata, exp_rdata);
         chk("R7", "busy", busy, 0);
         @(negedge clk);
         chk("R7", "no write strobe", bus_as_n, 1);
         chk("R6", "done one cycle", done, 0);
         return;
      end
      exp_rdata = v.rbus;
      chk("R3", "turn as_n", bus_as_n, 1);
      chk("R3", "turn doe", bus_doe, 0);
      chk("R4", "turn lock", bus_lock_n, 0);
      req_start = v.poke; bus_ready_n = !v.poke;
      @(negedge clk);                                    // write strobe
      chk("R3", "wr strobe as_n", bus_as_n, 0);
      chk("R3", "wr strobe rd_wr", bus_rd_wr, 0);
      chk("R3", "wr addr", bus_addr, v.addr);
      chk("R3", "wr data", bus_dout, v.wdata);
      chk("R5", "doe in write", bus_doe, 1);
      chk("R4", "lock at wr strobe", bus_lock_n, 0);
      bus_ready_n = !v.poke;
      @(negedge clk);                                    // first write wait
      req_start = 1'b0; bus_ready_n = 1'b1;
      for (int i = 0; i < int'(v.wwait); i++) begin
         chk("R8", "still in write wait", bus_lock_n, 0);
         chk("R5", "doe in write wait", bus_doe, 1);
         @(negedge clk);
      end
      bus_ready_n = 1'b0; bus_mexc_n = !v.wexc;
      @(negedge clk);
      bus_ready_n = 1'b1; bus_mexc_n = 1'b1;
      chk("R4", "lock released", bus_lock_n, 1);
      chk("R6", "done", done, 1);
      chk("R6", "resp", resp, v.wexc ? 2 : 0);
      chk("R6", "rdata", rdata, exp_rdata);
      chk("R9", "busy after", busy, 0);
      chk("R5", "doe off", bus_doe, 0);
      @(negedge clk);
      chk("R6", "done one cycle", done, 0);
      chk("R8", "no start from busy poke", bus_as_n, 1);
   endtask

   initial begin
      rst_n = 1'b0; req_start = 1'b0; req_addr = '0; req_wdata = '0;
      bus_din = '0; bus_ready_n = 1'b1; bus_mexc_n = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      idle_chk("R1");
      chk("R1", "done in reset", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      idle_chk("R1");
      bus_ready_n = 1'b0;                                // R8 ready while idle
      @(negedge clk);
      bus_ready_n = 1'b1;
      chk("R8", "idle ready no done", done, 0);
      idle_chk("R8");

      for (int k = 0; k < NV; k++) run_op(VEC[k]);

      // R1: reset during the write phase
      @(negedge clk);
      req_start = 1'b1; req_addr = 32'h0000_0BAD; req_wdata = 32'h1;
      @(negedge clk);
      req_start = 1'b0;
      @(negedge clk);
      bus_ready_n = 1'b0;
      @(negedge clk);
      bus_ready_n = 1'b1;
      @(negedge clk);
      chk("R3", "pre-reset write strobe", bus_as_n, 0);
      rst_n = 1'b0;
      #1;
      idle_chk("R1");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      idle_chk("R1");
      chk("R1", "rdata cleared", rdata, 0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule